// File: doc/BRIEF.md
# Page-Buffered Serial EEPROM Datapath

This block sits behind the bus front end of a serial EEPROM slave. The front end decodes the bus and hands over one-cycle byte events: an address byte arrived, a data byte arrived, a data byte is wanted, the master answered a read byte, and a stop was seen. The block keeps the byte-address counter, gathers written bytes into a 16-byte row buffer, and models the 512-byte storage as a register array. The array is split into two 256-byte pages, and an external page-select bit picks between them.

A stop that comes straight after a received data byte starts a timed internal write cycle. At the end of that cycle only the buffered bytes are copied into the array. While the cycle runs, `busy` is high and every event is ignored. The front end uses `busy` to withhold the acknowledge of the device select, so the master can poll until the write is done. Reads stream bytes from consecutive addresses until the master declines a byte.

Top module: `eeprom_page_datapath`

## Requirements
- R1: After reset, `busy` and `rd_drive` are 0 and every one of the 512 array bytes reads FFh.
- R2: `addr_ev` loads the 8-bit counter with `addr_byte`. Each `wdata_ev` stores `wdata` into the buffer slot named by the counter's low 4 bits, then advances only those 4 bits.
- R3: A write of more than 16 bytes wraps within the same 16-byte row. A later byte overwrites the buffered byte at the same slot. The counter's upper 4 bits never change on a write.
- R4: A write cycle starts only on a `stop_ev` whose previous accepted event was a `wdata_ev`. A stop after an address only, or after a read request that followed data, starts no cycle and discards the buffered bytes.
- R5: `busy` is high for exactly `WR_CYCLES` clock cycles after the committing stop. During that time all events are ignored: `rd_data` and the counter do not change.
- R6: `rd_req_ev` places the byte at address {`page_sel`, counter} on `rd_data` one cycle later, sets `rd_drive`, and increments the whole 8-bit counter. After FFh the counter wraps to 00h of the same page.
- R7: `mack_ev` with `mack_ok`=0 (no acknowledge) clears `rd_drive` in the next cycle. With `mack_ok`=1, `rd_drive` stays set.
- R8: A random read is `addr_ev` followed by `rd_req_ev` with no stop in between. It returns the addressed byte and writes nothing.
- R9: A current-address read with no new address continues from the counter left by the previous access. This includes the position after a page write.
- R10: The page selected when the address byte is accepted supplies address bit 8 of a write. The page at each read request supplies address bit 8 of that read.
- R11: Only buffer slots written since the address byte reach the array. The other bytes of the row keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_sel | input | 1 | Selected 256-byte page (address bit 8) |
| addr_ev | input | 1 | Address byte received |
| addr_byte | input | 8 | Received address byte |
| wdata_ev | input | 1 | Data byte received |
| wdata | input | 8 | Received data byte |
| rd_req_ev | input | 1 | Front end requests the next read byte |
| mack_ev | input | 1 | Master answered a read byte |
| mack_ok | input | 1 | 1 = master acknowledged, 0 = no acknowledge |
| stop_ev | input | 1 | Stop condition seen |
| busy | output | 1 | Internal write cycle running |
| rd_drive | output | 1 | Read stream active, front end drives data |
| rd_data | output | 8 | Byte to shift out |

## Verification
The bench writes all 512 bytes through full 16-byte page writes with an arithmetic pattern. It then streams each page back past its end, so that a wrong page bit, a counter that wraps across pages, or a counter that does not wrap at all would show up as mismatches. An overlong write starting near the end of a row checks that wrapping is confined to the low 4 bits. A design that carried into bit 4 would corrupt the next row. Stops after an address byte, or after a read that follows data, must leave `busy` low and the array untouched; a design that committed too eagerly would raise `busy` or alter those bytes. An address sent during the busy window must not move the counter, and the length of the busy window is counted cycle by cycle.

// File: rtl/eeprom_page_datapath.sv
module eeprom_page_datapath #(
  parameter int PAGE_AW   = 8,
  parameter int ROW_W     = 4,
  parameter int WR_CYCLES = 50000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               page_sel,
  input  logic               addr_ev,
  input  logic [PAGE_AW-1:0] addr_byte,
  input  logic               wdata_ev,
  input  logic [7:0]         wdata,
  input  logic               rd_req_ev,
  input  logic               mack_ev,
  input  logic               mack_ok,
  input  logic               stop_ev,
  output logic               busy,
  output logic               rd_drive,
  output logic [7:0]         rd_data
);
  localparam int ROW   = 1 << ROW_W;
  localparam int DEPTH = 2 << PAGE_AW;
  localparam int TW    = $clog2(WR_CYCLES + 1);
  localparam int HI_W  = PAGE_AW - ROW_W;

  logic [7:0]         mem [DEPTH];
  logic [7:0]         wbuf [ROW];
  logic [ROW-1:0]     wvld;
  logic [PAGE_AW-1:0] cnt;
  logic               wpage;
  logic               pend;
  logic [TW-1:0]      tmr;

  wire [ROW_W-1:0] slot = cnt[ROW_W-1:0];
  wire [HI_W-1:0]  row  = cnt[PAGE_AW-1:ROW_W];

  assign busy = (tmr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < ROW; i++) wbuf[i] <= 8'h00;
      wvld     <= '0;
      cnt      <= '0;
      wpage    <= 1'b0;
      pend     <= 1'b0;
      tmr      <= '0;
      rd_drive <= 1'b0;
      rd_data  <= 8'h00;
    end else if (busy) begin
      tmr <= tmr - TW'(1);
      if (tmr == TW'(1)) begin
        for (int i = 0; i < ROW; i++)
          if (wvld[i]) mem[{wpage, row, ROW_W'(i)}] <= wbuf[i];
        wvld <= '0;
      end
    end else if (addr_ev) begin
      cnt      <= addr_byte;
      wpage    <= page_sel;
      wvld     <= '0;
      pend     <= 1'b0;
      rd_drive <= 1'b0;
    end else if (wdata_ev) begin
      wbuf[slot]             <= wdata;
      wvld[slot]             <= 1'b1;
      cnt[ROW_W-1:0]         <= slot + ROW_W'(1);
      pend                   <= 1'b1;
    end else if (rd_req_ev) begin
      rd_data  <= mem[{page_sel, cnt}];
      cnt      <= cnt + PAGE_AW'(1);
      rd_drive <= 1'b1;
      pend     <= 1'b0;
      wvld     <= '0;
    end else if (mack_ev) begin
      if (!mack_ok) rd_drive <= 1'b0;
    end else if (stop_ev) begin
      rd_drive <= 1'b0;
      pend     <= 1'b0;
      if (pend && (wvld != '0)) tmr <= TW'(WR_CYCLES);
      else wvld <= '0;
    end
  end
endmodule

// File: rtl/eeprom_page_datapath_chk.sv
module eeprom_page_datapath_chk #(
  parameter int WR_CYCLES = 50000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_req_ev,
  input logic       mack_ev,
  input logic       mack_ok,
  input logic       stop_ev,
  input logic       busy,
  input logic       rd_drive,
  input logic [7:0] rd_data
);
  logic [31:0] busy_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_len <= '0;
    else busy_len <= busy ? busy_len + 32'd1 : 32'd0;

  // R4
  commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));

  // R5
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> busy_len == 32'(WR_CYCLES));

  // R5
  busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rd_data));

  // R6
  read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_ev && !busy) |=> rd_drive);

  // R7
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mack_ev && !mack_ok && !busy && !rd_req_ev) |=> !rd_drive);
endmodule

bind eeprom_page_datapath eeprom_page_datapath_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req_ev(rd_req_ev), .mack_ev(mack_ev),
  .mack_ok(mack_ok), .stop_ev(stop_ev), .busy(busy), .rd_drive(rd_drive),
  .rd_data(rd_data)
);

// File: tb/eeprom_page_datapath_test.sv
module eeprom_page_datapath_test;
  localparam int WRC = 20;

  logic clk = 0, rst_n = 0;
  logic page_sel = 0, addr_ev = 0, wdata_ev = 0, rd_req_ev = 0;
  logic mack_ev = 0, mack_ok = 0, stop_ev = 0;
  logic [7:0] addr_byte = 0, wdata = 0;
  logic busy, rd_drive;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  logic [7:0] exp_mem [512];

  always #5 clk = ~clk;

  eeprom_page_datapath #(.PAGE_AW(8), .ROW_W(4), .WR_CYCLES(WRC)) uut (.*);

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37) + (a >> 8) * 91 + 5);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_addr(int a, bit pg);
    @(negedge clk); page_sel = pg; addr_byte = 8'(a); addr_ev = 1;
    @(negedge clk); addr_ev = 0;
  endtask
  task automatic pulse_wr(logic [7:0] d);
    @(negedge clk); wdata = d; wdata_ev = 1;
    @(negedge clk); wdata_ev = 0;
  endtask
  task automatic pulse_rd(bit pg, output logic [7:0] d);
    @(negedge clk); page_sel = pg; rd_req_ev = 1;
    @(negedge clk); rd_req_ev = 0; d = rd_data;
  endtask
  task automatic pulse_ack(bit ok);
    @(negedge clk); mack_ok = ok; mack_ev = 1;
    @(negedge clk); mack_ev = 0;
  endtask
  task automatic pulse_stop(output int blen);
    @(negedge clk); stop_ev = 1;
    @(negedge clk); stop_ev = 0;
    blen = 0;
    while (busy) begin blen++; @(negedge clk); end
  endtask

  initial begin
    automatic logic [7:0] d;
    automatic int bl;
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 rd_drive", rd_drive, 0);

    // R1: erased content on both pages
    for (int p = 0; p < 2; p++) begin
      pulse_addr(0, 1'(p));
      for (int i = 0; i < 256; i++) begin
        pulse_rd(1'(p), d);
        check("R1 erased", d, 8'hFF);
        pulse_ack(i != 255);
      end
      pulse_stop(bl);
      check("R1 no busy", bl, 0);
    end

    // R2 R3 R10: full page writes over the whole array
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 16; r++) begin
        pulse_addr(r * 16, 1'(p));
        for (int k = 0; k < 16; k++) begin
          pulse_wr(pat(p * 256 + r * 16 + k));
          exp_mem[p * 256 + r * 16 + k] = pat(p * 256 + r * 16 + k);
        end
        pulse_stop(bl);
        check("R5 busy length", bl, WRC);
      end

    // R6 R8 R10: stream each page past its end, then R7
    for (int p = 0; p < 2; p++) begin
      pulse_addr(0, 1'(p));
      for (int i = 0; i < 257; i++) begin
        pulse_rd(1'(p), d);
        check("R6 R10 stream", d, exp_mem[p * 256 + (i % 256)]);
        check("R6 drive", rd_drive, 1);
        pulse_ack(i != 256);
      end
      check("R7 nack releases", rd_drive, 0);
    end

    // R3 R11: overlong write from 0x2E wraps in row 0x20
    pulse_addr(8'h2E, 0);
    for (int k = 0; k < 20; k++) begin
      pulse_wr(8'hA0 + 8'(k));
      exp_mem[8'h20 + ((14 + k) % 16)] = 8'hA0 + 8'(k);
    end
    pulse_stop(bl);
    check("R3 busy", bl, WRC);
    // R9: counter after wrap sits at 0x20 + (14+20)%16 = 0x22
    pulse_rd(0, d);
    check("R9 current read", d, exp_mem[8'h22]);
    pulse_ack(0);
    pulse_addr(8'h1F, 0);
    for (int i = 0; i < 18; i++) begin
      pulse_rd(0, d);
      check("R3 row wrap", d, exp_mem[8'h1F + i]);
      pulse_ack(i != 17);
    end

    // R4: stop after address only
    pulse_addr(8'h50, 0);
    pulse_stop(bl);
    check("R4 addr stop", bl, 0);
    // R4 R8: data then random read then stop discards
    pulse_addr(8'h60, 1);
    pulse_wr(8'h11);
    pulse_rd(1, d);
    check("R8 random read", d, exp_mem[256 + 8'h61]);
    pulse_ack(0);
    pulse_stop(bl);
    check("R4 discard", bl, 0);
    pulse_addr(8'h60, 1);
    pulse_rd(1, d);
    check("R4 untouched", d, exp_mem[256 + 8'h60]);
    pulse_ack(0);
    pulse_stop(bl);

    // R5 R11: byte write, address ignored while busy
    pulse_addr(8'h70, 1);
    pulse_wr(8'h5A);
    exp_mem[256 + 8'h70] = 8'h5A;
    @(negedge clk); stop_ev = 1;
    @(negedge clk); stop_ev = 0;
    check("R5 busy raised", busy, 1);
    pulse_addr(8'h10, 0);
    pulse_rd(0, d);
    while (busy) @(negedge clk);
    pulse_rd(1, d);
    check("R5 ignored during busy", d, exp_mem[256 + 8'h71]);
    pulse_ack(0);
    pulse_addr(8'h6F, 1);
    for (int i = 0; i < 3; i++) begin
      pulse_rd(1, d);
      check("R11 partial row", d, exp_mem[256 + 8'h6F + i]);
      pulse_ack(i != 2);
    end
    // R10: page 0 at same address unaffected
    pulse_addr(8'h70, 0);
    pulse_rd(0, d);
    check("R10 page 0 kept", d, exp_mem[8'h70]);
    pulse_ack(0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule